// File: doc/BRIEF.md
# Three-Error-Correcting Quadratic-Residue Codec, Length 31

This block protects short control messages on a noisy link. On the transmit side it takes a 16-bit message and produces a 31-bit codeword. The message is sent as it is, and fifteen check bits are added below it. The code is the binary cyclic quadratic-residue code of length 31. Its generator has degree 15, and its roots are the powers of a primitive element whose exponents are the nonzero squares modulo 31. Any two codewords differ in at least seven places. This makes the code a good fit for many short frames, where a long iterative code would waste both latency and logic.

On the receive side a four-stage pipeline takes one 31-bit word per cycle and returns the nearest codeword and its message field. It can correct up to three flipped bits anywhere in the word. The first stage registers the word and the second forms the syndrome. The third stage runs search paths side by side, each keyed on how many errors it assumes fell in the message field (none, one, two or three). Each path tests whether the leftover syndrome is light enough to be an error in the check bits. The last stage takes the single path that matches. It applies the correction, or it raises a flag when no path matched. The encoder and the decoder work independently of each other.

Top module: `qr31_codec`

## Requirements
- R1: One cycle after a message is accepted, `enc_word[30:15]` equals that message bit for bit.
- R2: Read as a polynomial with bit i as the coefficient of x^i, every `enc_word` is divisible by g(x) = x^15 + x^14 + x^13 + x^9 + x^8 + x^3 + 1. So `enc_word[14:0]` is the remainder of message·x^15 divided by g(x).
- R3: `enc_valid_out` is `enc_valid_in` delayed by exactly one cycle, and a new message is accepted on every cycle.
- R4: `dec_valid_out` is `dec_valid_in` delayed by exactly four cycles. A new word is accepted on every cycle, and results leave in the order the words arrived.
- R5: A received word that is already a codeword leaves unchanged, with `dec_uncorr` low.
- R6: A codeword with one, two or three bits flipped, at any positions, comes out restored to the original codeword, with `dec_uncorr` low.
- R7: `dec_msg_out` equals bits 30 down to 15 of the `dec_word_out` issued in the same cycle.
- R8: When no error pattern of weight three or less accounts for the syndrome, `dec_uncorr` is high and `dec_word_out` equals the received word.
- R9: While `rst_n` is low and after it rises, both valid outputs stay low until a valid input has passed through its pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid_in | input | 1 | Message on `enc_msg` is valid this cycle |
| enc_msg | input | 16 | Message to encode |
| enc_valid_out | output | 1 | `enc_word` is valid |
| enc_word | output | 31 | Systematic codeword: message high, check bits low |
| dec_valid_in | input | 1 | Word on `dec_word_in` is valid this cycle |
| dec_word_in | input | 31 | Received word |
| dec_valid_out | output | 1 | Decoder outputs are valid |
| dec_word_out | output | 31 | Corrected word, or the received word if it cannot be corrected |
| dec_msg_out | output | 16 | Message field of `dec_word_out` |
| dec_uncorr | output | 1 | High when the word could not be corrected |

## Verification
On every cycle the bound checker confirms several properties. Each encoder word carries its message and divides by g(x), and both valid signals keep their fixed delays. Every decoder result that is not flagged is a codeword within distance three of the word that came in, and its message field matches it. A flagged result equals its input, a clean input passes through untouched, and reset leaves the valid outputs quiet. Some things only the bench's scenarios can show. The decoder must find the right codeword and not just some nearby one, every single-bit position must be covered, and fixed two-error and three-error patterns must be placed at the ends of the word and across the boundary between message and check bits. Heavy error patterns must actually set the flag, and streams must run back to back with gaps while the encoder works in the same cycles.

// File: rtl/qr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the length-31 quadratic-residue codec.
// Assumes: the generator is fixed. Its roots are the powers alpha^q, where q
// runs over the squares mod 31 and alpha is a root of x^5 + x^2 + 1.
package qr_pkg;
    localparam int N   = 31;          // codeword length
    localparam int K   = 16;          // message length
    localparam int R   = N - K;       // check bits = generator degree
    localparam int T   = 3;           // correctable errors
    localparam int NPATH = T + 1;     // search paths: message-field error count 0..T
    localparam logic [R:0] GEN_POLY = 16'hE309; // x^15+x^14+x^13+x^9+x^8+x^3+1

    // Residue of x^k modulo the generator (k below N).
    function automatic logic [R-1:0] xpow_mod(input int k);
        logic [R-1:0] acc;
        acc = {{(R-1){1'b0}}, 1'b1};
        for (int n = 0; n < N; n++) begin
            if (n < k) begin
                acc = {acc[R-2:0], 1'b0} ^ (acc[R-1] ? GEN_POLY[R-1:0] : '0);
            end
        end
        return acc;
    endfunction
endpackage

// File: rtl/qr_parity_gen.sv
`timescale 1ns/1ps
// Combinational residue of msg(x)*x^R modulo the generator.
// The encoder uses it for the check bits, and the decoder uses it to fold the
// message field of a received word into its syndrome.
// Assumes: constant columns fold at elaboration; the tree is K-wide XOR.
module qr_parity_gen
    import qr_pkg::*;
(
    input  logic [K-1:0] msg,
    output logic [R-1:0] rem
);
    logic [R-1:0] term [K];

    for (genvar i = 0; i < K; i++) begin : g_col
        localparam logic [R-1:0] COL = xpow_mod(R + i);
        assign term[i] = msg[i] ? COL : '0;
    end

    // Purpose: XOR together the columns chosen by the message bits.
    always_comb begin
        rem = '0;
        for (int i = 0; i < K; i++) begin
            rem = rem ^ term[i];
        end
    end
endmodule

// File: rtl/qr_err_search.sv
`timescale 1ns/1ps
// One search path of the decoder. It assumes exactly W errors lie in the
// message field (bits N-1..R). For every such hypothesis it removes their
// syndrome contribution. Whatever is left must be an error confined to the
// check bits, and it must weigh at most T-W.
// Assumes: distance 7, so at most one hypothesis over all paths can match.
// Outputs are meaningful only when hit is high.
module qr_err_search
    import qr_pkg::*;
#(
    parameter int W = 1
) (
    input  logic [R-1:0] syn,
    output logic         hit,
    output logic [K-1:0] msg_err,
    output logic [R-1:0] par_err
);
    localparam int SLACK = T - W;

    logic [R-1:0] col [K];
    for (genvar i = 0; i < K; i++) begin : g_col
        assign col[i] = xpow_mod(R + i);
    end

    if (W == 0) begin : g_w0
        // Purpose: all errors (if any) sit in the check bits.
        always_comb begin
            hit     = ($countones(syn) <= SLACK);
            msg_err = '0;
            par_err = syn;
        end
    end else if (W == 1) begin : g_w1
        // Purpose: try each single message-bit error.
        always_comb begin
            hit = 1'b0; msg_err = '0; par_err = '0;
            for (int i = 0; i < K; i++) begin
                if ($countones(syn ^ col[i]) <= SLACK) begin
                    hit = 1'b1;
                    msg_err = '0;
                    msg_err[i] = 1'b1;
                    par_err = syn ^ col[i];
                end
            end
        end
    end else if (W == 2) begin : g_w2
        // Purpose: try each pair of message-bit errors.
        always_comb begin
            hit = 1'b0; msg_err = '0; par_err = '0;
            for (int i = 0; i < K; i++) begin
                for (int j = i + 1; j < K; j++) begin
                    if ($countones(syn ^ col[i] ^ col[j]) <= SLACK) begin
                        hit = 1'b1;
                        msg_err = '0;
                        msg_err[i] = 1'b1;
                        msg_err[j] = 1'b1;
                        par_err = syn ^ col[i] ^ col[j];
                    end
                end
            end
        end
    end else begin : g_w3
        // Purpose: try each triple of message-bit errors (no check-bit slack).
        always_comb begin
            hit = 1'b0; msg_err = '0; par_err = '0;
            for (int i = 0; i < K; i++) begin
                for (int j = i + 1; j < K; j++) begin
                    for (int k = j + 1; k < K; k++) begin
                        if ($countones(syn ^ col[i] ^ col[j] ^ col[k]) <= SLACK) begin
                            hit = 1'b1;
                            msg_err = '0;
                            msg_err[i] = 1'b1;
                            msg_err[j] = 1'b1;
                            msg_err[k] = 1'b1;
                            par_err = syn ^ col[i] ^ col[j] ^ col[k];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/qr31_codec.sv
`timescale 1ns/1ps
// Length-31 quadratic-residue codec: a one-cycle systematic encoder and a
// four-cycle decoder that corrects three errors.
// Decoder stages: 1 register input, 2 syndrome, 3 parallel search paths,
// 4 select, correct and flag.
// Assumes: one word per cycle on each side, no back-pressure.
module qr31_codec
    import qr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enc_valid_in,
    input  logic [K-1:0] enc_msg,
    output logic         enc_valid_out,
    output logic [N-1:0] enc_word,
    input  logic         dec_valid_in,
    input  logic [N-1:0] dec_word_in,
    output logic         dec_valid_out,
    output logic [N-1:0] dec_word_out,
    output logic [K-1:0] dec_msg_out,
    output logic         dec_uncorr
);
    // ---------------- encoder ----------------
    logic [R-1:0] enc_par;

    qr_parity_gen u_enc_par (.msg(enc_msg), .rem(enc_par));

    // Purpose: register the systematic codeword and its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_valid_out <= 1'b0;
            enc_word      <= '0;
        end else begin
            enc_valid_out <= enc_valid_in;
            enc_word      <= {enc_msg, enc_par};
        end
    end

    // ---------------- decoder ----------------
    logic [3:1]   dv;              // valid through stages 1..3
    logic [N-1:0] s1_word, s2_word, s3_word;
    logic [R-1:0] s1_fold, s2_syn;
    logic [NPATH-1:0] srch_hit, s3_hit;
    logic [K-1:0] srch_msg [NPATH];
    logic [R-1:0] srch_par [NPATH];
    logic [K-1:0] s3_msg   [NPATH];
    logic [R-1:0] s3_par   [NPATH];
    logic         any_hit;
    logic [N-1:0] fix, corr;

    qr_parity_gen u_syn_fold (.msg(s1_word[N-1:R]), .rem(s1_fold));

    // Purpose: move the valid flag along the four decoder stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv            <= '0;
            dec_valid_out <= 1'b0;
        end else begin
            dv            <= {dv[2:1], dec_valid_in};
            dec_valid_out <= dv[3];
        end
    end

    // Purpose: stages 1-2, capture the word and then its syndrome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_word <= '0;
            s2_word <= '0;
            s2_syn  <= '0;
        end else begin
            s1_word <= dec_word_in;
            s2_word <= s1_word;
            s2_syn  <= s1_word[R-1:0] ^ s1_fold;
        end
    end

    for (genvar w = 0; w < NPATH; w++) begin : g_path
        qr_err_search #(.W(w)) u_srch (
            .syn    (s2_syn),
            .hit    (srch_hit[w]),
            .msg_err(srch_msg[w]),
            .par_err(srch_par[w])
        );
    end

    // Purpose: stage 3, register the outcome of every search path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_word <= '0;
            s3_hit  <= '0;
            for (int w = 0; w < NPATH; w++) begin
                s3_msg[w] <= '0;
                s3_par[w] <= '0;
            end
        end else begin
            s3_word <= s2_word;
            s3_hit  <= srch_hit;
            for (int w = 0; w < NPATH; w++) begin
                s3_msg[w] <= srch_msg[w];
                s3_par[w] <= srch_par[w];
            end
        end
    end

    // Purpose: take the one matching path's error pattern (none if no hit).
    always_comb begin
        any_hit = 1'b0;
        fix     = '0;
        for (int w = 0; w < NPATH; w++) begin
            if (s3_hit[w]) begin
                any_hit = 1'b1;
                fix     = {s3_msg[w], s3_par[w]};
            end
        end
        corr = s3_word ^ fix;
    end

    // Purpose: stage 4, register the corrected word, its message and the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_word_out <= '0;
            dec_msg_out  <= '0;
            dec_uncorr   <= 1'b0;
        end else begin
            dec_word_out <= corr;
            dec_msg_out  <= corr[N-1:R];
            dec_uncorr   <= ~any_hit;
        end
    end
endmodule

// File: rtl/qr31_codec_chk.sv
`timescale 1ns/1ps
// Property checker for qr31_codec, attached with bind below.
// Assumes: synchronous active-low reset. A saturating count of cycles since
// reset gates every $past so that no check reaches back into reset.
module qr31_codec_chk
    import qr_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         enc_valid_in,
    input logic [K-1:0] enc_msg,
    input logic         enc_valid_out,
    input logic [N-1:0] enc_word,
    input logic         dec_valid_in,
    input logic [N-1:0] dec_word_in,
    input logic         dec_valid_out,
    input logic [N-1:0] dec_word_out,
    input logic [K-1:0] dec_msg_out,
    input logic         dec_uncorr
);
    logic [2:0] since_rst;

    // Purpose: count cycles out of reset, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // Long division remainder, bit-serial from the top.
    function automatic logic [R-1:0] chk_rem(input logic [N-1:0] w);
        logic [N-1:0] x;
        x = w;
        for (int i = N - 1; i >= R; i--) begin
            if (x[i]) x = x ^ ({{(N-R-1){1'b0}}, GEN_POLY} << (i - R));
        end
        return x[R-1:0];
    endfunction

    p_enc_sys_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && enc_valid_out) |-> enc_word[N-1:R] == $past(enc_msg));

    p_enc_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_out |-> chk_rem(enc_word) == '0);

    p_enc_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 3'd1 |-> enc_valid_out == $past(enc_valid_in));

    p_dec_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 3'd4 |-> dec_valid_out == $past(dec_valid_in, 4));

    p_dec_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && dec_valid_out && chk_rem($past(dec_word_in, 4)) == '0)
        |-> (!dec_uncorr && dec_word_out == $past(dec_word_in, 4)));

    p_dec_near_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && dec_valid_out && !dec_uncorr)
        |-> (chk_rem(dec_word_out) == '0
             && $countones(dec_word_out ^ $past(dec_word_in, 4)) <= T));

    p_dec_msg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_out && !dec_uncorr) |-> chk_rem({dec_msg_out, dec_word_out[R-1:0]}) == '0);

    p_dec_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && dec_valid_out && dec_uncorr)
        |-> dec_word_out == $past(dec_word_in, 4));

    p_rst_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!enc_valid_out && !dec_valid_out));
endmodule

bind qr31_codec qr31_codec_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_valid_in (enc_valid_in),
    .enc_msg      (enc_msg),
    .enc_valid_out(enc_valid_out),
    .enc_word     (enc_word),
    .dec_valid_in (dec_valid_in),
    .dec_word_in  (dec_word_in),
    .dec_valid_out(dec_valid_out),
    .dec_word_out (dec_word_out),
    .dec_msg_out  (dec_msg_out),
    .dec_uncorr   (dec_uncorr)
);

// File: tb/test_qr31_codec.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes expected results with a brute-force
// reference decoder and queues them; a monitor pops and compares on output.
module test_qr31_codec;
    localparam logic [15:0] G_REF = 16'hE309;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_in = 1'b0;
    logic [15:0] enc_msg = '0;
    logic        enc_valid_out;
    logic [30:0] enc_word;
    logic        dec_valid_in = 1'b0;
    logic [30:0] dec_word_in = '0;
    logic        dec_valid_out;
    logic [30:0] dec_word_out;
    logic [15:0] dec_msg_out;
    logic        dec_uncorr;

    int n_chk = 0;
    int n_err = 0;
    int n_flag = 0;
    int cyc = 0;
    bit [31:0] rng = 32'h2468_ACE1;

    logic [30:0] q_enc_w [$];
    int          q_enc_t [$];
    logic [30:0] q_dec_w [$];
    logic        q_dec_f [$];
    int          q_dec_t [$];
    string       q_dec_tag [$];
    logic [14:0] ps [31];

    always #2.5 clk = ~clk;

    qr31_codec i_qr31_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_in(enc_valid_in), .enc_msg(enc_msg),
        .enc_valid_out(enc_valid_out), .enc_word(enc_word),
        .dec_valid_in(dec_valid_in), .dec_word_in(dec_word_in),
        .dec_valid_out(dec_valid_out), .dec_word_out(dec_word_out),
        .dec_msg_out(dec_msg_out), .dec_uncorr(dec_uncorr)
    );

    function automatic bit [31:0] nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic [14:0] b_rem(input logic [30:0] w);
        logic [30:0] x;
        x = w;
        for (int i = 30; i >= 15; i--)
            if (x[i]) x = x ^ ({15'b0, G_REF} << (i - 15));
        return x[14:0];
    endfunction

    function automatic logic [30:0] b_encode(input logic [15:0] m);
        return {m, b_rem({m, 15'b0})};
    endfunction

    // Returns {uncorrectable, decoded word}; exhaustive over weight <= 3.
    function automatic logic [31:0] b_decode(input logic [30:0] w);
        logic [14:0] s;
        s = b_rem(w);
        if (s == '0) return {1'b0, w};
        for (int i = 0; i < 31; i++)
            if (ps[i] == s) return {1'b0, w ^ (31'(1) << i)};
        for (int i = 0; i < 31; i++)
            for (int j = i + 1; j < 31; j++)
                if ((ps[i] ^ ps[j]) == s) return {1'b0, w ^ (31'(1) << i) ^ (31'(1) << j)};
        for (int i = 0; i < 31; i++)
            for (int j = i + 1; j < 31; j++)
                for (int k = j + 1; k < 31; k++)
                    if ((ps[i] ^ ps[j] ^ ps[k]) == s)
                        return {1'b0, w ^ (31'(1) << i) ^ (31'(1) << j) ^ (31'(1) << k)};
        return {1'b1, w};
    endfunction

    // Word with `nerr` distinct random bit flips.
    function automatic logic [30:0] flip(input logic [30:0] c, input int nerr);
        logic [30:0] e;
        e = '0;
        while ($countones(e) < nerr) e[nxt() % 31] = 1'b1;
        return c ^ e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit ev, input logic [15:0] m, input bit dv,
                        input logic [30:0] w, input string tag);
        logic [31:0] r;
        @(negedge clk);
        enc_valid_in = ev; enc_msg = m;
        dec_valid_in = dv; dec_word_in = w;
        if (ev) begin
            q_enc_w.push_back(b_encode(m));
            q_enc_t.push_back(cyc + 1);
        end
        if (dv) begin
            r = b_decode(w);
            q_dec_w.push_back(r[30:0]);
            q_dec_f.push_back(r[31]);
            q_dec_t.push_back(cyc + 4);
            q_dec_tag.push_back(tag);
            if (r[31]) n_flag++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, "");
    endtask

    task automatic dec_err(input int nerr, input string tag);
        step(1'b0, '0, 1'b1, flip(b_encode(nxt() % 65536), nerr), tag);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk++;
            n_err++;
            $display("FAIL R4 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    // Monitor: pop and compare as results appear.
    always @(negedge clk) begin
        logic [30:0] ew;
        logic ef;
        int et;
        string tg;
        if (rst_n) begin
            if (enc_valid_out) begin
                if (q_enc_w.size() == 0) begin
                    chk(1'b0, "R3 spurious enc_valid_out", 32'd1, 32'd0);
                end else begin
                    ew = q_enc_w.pop_front();
                    et = q_enc_t.pop_front();
                    chk(enc_word[30:15] == ew[30:15], "R1 message field", 32'(enc_word[30:15]), 32'(ew[30:15]));
                    chk(enc_word == ew, "R2 check bits", 32'(enc_word), 32'(ew));
                    chk(cyc == et, "R3 enc latency", 32'(cyc), 32'(et));
                end
            end
            if (dec_valid_out) begin
                if (q_dec_w.size() == 0) begin
                    chk(1'b0, "R4 spurious dec_valid_out", 32'd1, 32'd0);
                end else begin
                    ew = q_dec_w.pop_front();
                    ef = q_dec_f.pop_front();
                    et = q_dec_t.pop_front();
                    tg = q_dec_tag.pop_front();
                    chk(dec_word_out == ew, {tg, " word"}, 32'(dec_word_out), 32'(ew));
                    chk(dec_uncorr == ef, {tg, " flag"}, 32'(dec_uncorr), 32'(ef));
                    chk(dec_msg_out == ew[30:15], "R7 message out", 32'(dec_msg_out), 32'(ew[30:15]));
                    chk(cyc == et, "R4 dec latency", 32'(cyc), 32'(et));
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 31; i++) ps[i] = b_rem(31'(1) << i);

        // R9: valid inputs held high during reset must not leak out.
        enc_valid_in = 1'b1; dec_valid_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(!enc_valid_out && !dec_valid_out, "R9 valid during reset",
            {30'b0, enc_valid_out, dec_valid_out}, 32'd0);
        rst_n = 1'b1;
        enc_valid_in = 1'b0; dec_valid_in = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!enc_valid_out && !dec_valid_out, "R9 valid after reset",
                {30'b0, enc_valid_out, dec_valid_out}, 32'd0);
        end

        // R1 R2 R3: corner messages then a random back-to-back burst.
        step(1'b1, 16'h0000, 1'b0, '0, "");
        step(1'b1, 16'hFFFF, 1'b0, '0, "");
        step(1'b1, 16'h0001, 1'b0, '0, "");
        step(1'b1, 16'h8000, 1'b0, '0, "");
        step(1'b1, 16'hA5A5, 1'b0, '0, "");
        idle(2);
        for (int i = 0; i < 40; i++) step(1'b1, 16'(nxt()), 1'b0, '0, "");
        idle(3);

        // R5: clean codewords, including all-zero and all-ones message.
        step(1'b0, '0, 1'b1, b_encode(16'h0000), "R5 clean");
        step(1'b0, '0, 1'b1, b_encode(16'hFFFF), "R5 clean");
        for (int i = 0; i < 20; i++) step(1'b0, '0, 1'b1, b_encode(16'(nxt())), "R5 clean");
        idle(2);

        // R6: every single-bit position.
        for (int p = 0; p < 31; p++)
            step(1'b0, '0, 1'b1, b_encode(16'(nxt())) ^ (31'(1) << p), "R6 single");
        // R6: fixed patterns at the ends and across the message/check boundary.
        step(1'b0, '0, 1'b1, b_encode(16'h1234) ^ 31'h0000_0007, "R6 low triple");
        step(1'b0, '0, 1'b1, b_encode(16'h1234) ^ 31'h7000_0000, "R6 high triple");
        step(1'b0, '0, 1'b1, b_encode(16'hBEEF) ^ 31'h0001_C000, "R6 boundary triple");
        step(1'b0, '0, 1'b1, b_encode(16'hC0DE) ^ 31'h4000_8001, "R6 spread triple");
        step(1'b0, '0, 1'b1, b_encode(16'h0F0F) ^ 31'h0000_C000, "R6 boundary pair");
        for (int i = 0; i < 60; i++) dec_err(2, "R6 double");
        for (int i = 0; i < 80; i++) begin
            dec_err(3, "R6 triple");
            if (nxt() % 4 == 0) idle(1);
        end
        idle(2);

        // R8: heavy damage; reference decides correct versus flagged.
        for (int i = 0; i < 50; i++) dec_err(4, "R8 four");
        for (int i = 0; i < 30; i++) dec_err(5, "R8 five");
        for (int i = 0; i < 30; i++) step(1'b0, '0, 1'b1, 31'(nxt()), "R8 random");

        // R3 R4: both sides streaming in the same cycles.
        for (int i = 0; i < 40; i++)
            step(1'b1, 16'(nxt()), 1'b1, flip(b_encode(16'(nxt())), i % 4), "R4 stream");
        idle(8);

        chk(n_flag > 0, "R8 flagged words seen", 32'(n_flag), 32'd1);
        chk(q_enc_w.size() == 0, "R3 encoder results outstanding", 32'(q_enc_w.size()), 32'd0);
        chk(q_dec_w.size() == 0, "R4 decoder results outstanding", 32'(q_dec_w.size()), 32'd0);
        summary();
        $finish;
    end
endmodule